// File: doc/BRIEF.md
# System Coprocessor Control Register File

This block holds the privileged control registers of a simple RISC core's system coprocessor. The core's move-to and move-from coprocessor instructions present an access with a 5-bit register number. A move-to writes on the next clock edge. A move-from returns data combinationally in the same cycle. The block keeps a status word, and the low six bits of that word form a three-level stack of (user-mode, interrupt-enable) pairs. It also keeps a faulting-address register, a cause stub that records the exception code, the exception return PC, and two byte-wide registers for talking to an external test host.

Exception entry and return-from-exception arrive as single-cycle pulses from the pipeline. On entry the mode stack is pushed and the core drops into kernel mode with interrupts disabled. On return the stack is popped. Each access is checked against the usable rule. An access that fails the check raises a fault output and has no effect. The counter/timer registers live in a separate block. This block only routes their read values in and their write strobes out.

Top module: `cop_ctrl_regs`

## Requirements
- R1: After reset the status word, the exception PC, the faulting address, the cause stub, both host registers and `host_out` are all zero. A zero status means kernel mode with interrupts disabled.
- R2: The status word keeps only bit 28 (usable flag of coprocessor 0), bits 15:8 (interrupt mask) and bits 5:0 (mode stack). All other bits, including 31:29, read as zero. For example, writing 0xFFFFFFFF to register 12 reads back 0x1000FF3F.
- R3: Status bit 1 set means user mode. In user mode, an access (`acc_valid`=1) is allowed only if status bit 28 is set. A refused access drives `unusable_fault`=1 in the same cycle, returns `rd_data`=0 and changes no register. In kernel mode, accesses are always allowed.
- R4: When `exc_enter` is high, the stack bits 5:0 become {old bits 3:0, 2'b00}. Register 14 loads `exc_pc`, register 8 loads `exc_badaddr`, and register 13 reads `exc_code` in bits 6:2 with zeros elsewhere.
- R5: When `exc_return` is high without `exc_enter`, the stack bits 5:0 become {old bits 5:4, old bits 5:2}.
- R6: `exc_enter` squashes any move-to in the same cycle, including strobes to the timer, and it overrides `exc_return`. A move-to status in the same cycle as a lone `exc_return` takes precedence over the pop.
- R7: Register 20 reads {24'b0, host byte}. The host byte is loaded from `host_wdata` whenever `host_wr` is high. Core writes to register 20 are ignored.
- R8: A move-to register 21 stores the low 8 bits of the data. The stored byte reads back zero-extended and drives `host_out`.
- R9: A read of register 9 returns `count_val` and a read of register 11 returns `compare_val`. An allowed write to either register pulses `tmr_we` in that cycle, with `tmr_sel` set to 0 for register 9 and 1 for register 11.
- R10: Registers 8 and 13 ignore move-to. All register numbers other than 8, 9, 11, 12, 13, 14, 20 and 21 read as zero and ignore writes.
- R11: `kernel_mode` is the inverse of status bit 1, `irq_enable` is status bit 0, and `irq_mask` is status bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Coprocessor access this cycle |
| acc_write | input | 1 | 1 = move-to, 0 = move-from |
| acc_addr | input | 5 | Register number |
| acc_wdata | input | 32 | Move-to data |
| rd_data | output | 32 | Move-from data (combinational) |
| unusable_fault | output | 1 | Access refused by usable rule |
| exc_enter | input | 1 | Exception entry pulse |
| exc_return | input | 1 | Return-from-exception pulse |
| exc_pc | input | 32 | PC to save on entry |
| exc_badaddr | input | 32 | Faulting address to save on entry |
| exc_code | input | 5 | Exception code to record on entry |
| host_wr | input | 1 | Host loads its input byte |
| host_wdata | input | 8 | Byte from host |
| host_out | output | 8 | Byte to host |
| count_val | input | 32 | Counter value from timer block |
| compare_val | input | 32 | Compare value from timer block |
| tmr_we | output | 1 | Write strobe to timer block |
| tmr_sel | output | 1 | 0 = counter, 1 = compare |
| kernel_mode | output | 1 | Core is in kernel mode |
| irq_enable | output | 1 | Current interrupt enable |
| irq_mask | output | 8 | Interrupt mask |

## Verification
Three functions can collide in one cycle: an exception-entry pulse can coincide with a move-to to status, to the timer or to the host byte, and a return pulse can coincide with a move-to to status. The bench drives these pairs together on purpose, and also drives entry and return together. A behavioural model applies the stated precedence, and the bench compares the fault, read data, timer strobe and mode outputs against that model on every clock. A host load of the input byte during a core read of it is also exercised, and the read must show the value held before that edge.

// File: rtl/cop_regs_pkg.sv
package cop_regs_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 32;
    localparam int HOST_W  = 8;
    localparam int CODE_W  = 5;
    localparam int PAIRS   = 3;
    localparam int STK_W   = 2 * PAIRS;
    localparam int MASK_W  = 8;

    localparam logic [ADDR_W-1:0] RN_BADADDR = 5'd8;
    localparam logic [ADDR_W-1:0] RN_COUNT   = 5'd9;
    localparam logic [ADDR_W-1:0] RN_COMPARE = 5'd11;
    localparam logic [ADDR_W-1:0] RN_STATUS  = 5'd12;
    localparam logic [ADDR_W-1:0] RN_CAUSE   = 5'd13;
    localparam logic [ADDR_W-1:0] RN_EPC     = 5'd14;
    localparam logic [ADDR_W-1:0] RN_HOSTIN  = 5'd20;
    localparam logic [ADDR_W-1:0] RN_HOSTOUT = 5'd21;

    typedef struct packed {
        logic              cu0;
        logic [MASK_W-1:0] im;
        logic [STK_W-1:0]  stk;
    } stat_t;

    typedef struct packed {
        stat_t             stat;
        logic [DATA_W-1:0] epc;
        logic [DATA_W-1:0] bad;
        logic [CODE_W-1:0] code;
        logic [HOST_W-1:0] hin;
        logic [HOST_W-1:0] hout;
    } regs_t;

    function automatic logic [DATA_W-1:0] stat_word(stat_t s);
        stat_word = '0;
        stat_word[28]   = s.cu0;
        stat_word[15:8] = s.im;
        stat_word[STK_W-1:0] = s.stk;
    endfunction
endpackage

// File: rtl/cop_access_check.sv
module cop_access_check
    import cop_regs_pkg::*;
(
    input  logic acc_valid,
    input  logic acc_write,
    input  logic user_mode,
    input  logic cu0,
    input  logic exc_enter,
    output logic fault,
    output logic rd_ok,
    output logic wr_ok
);
    logic allowed;

    always_comb begin
        allowed = !user_mode || cu0;
        fault   = acc_valid && !allowed;
        rd_ok   = acc_valid && allowed && !acc_write;
        wr_ok   = acc_valid && allowed && acc_write && !exc_enter;
    end
endmodule

// File: rtl/cop_mode_stack.sv
module cop_mode_stack
    import cop_regs_pkg::*;
#(
    parameter int N_PAIRS = PAIRS
) (
    input  logic [2*N_PAIRS-1:0] stk_q,
    input  logic                 push,
    input  logic                 pop,
    output logic [2*N_PAIRS-1:0] stk_d
);
    for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
        logic [1:0] below;
        logic [1:0] above;
        if (i == 0) begin : g_bot
            assign below = 2'b00;
        end else begin : g_mid
            assign below = stk_q[2*i-1 -: 2];
        end
        if (i == N_PAIRS-1) begin : g_top
            assign above = stk_q[2*i+1 -: 2];
        end else begin : g_low
            assign above = stk_q[2*i+3 -: 2];
        end
        always_comb begin
            if (push)     stk_d[2*i+1 -: 2] = below;
            else if (pop) stk_d[2*i+1 -: 2] = above;
            else          stk_d[2*i+1 -: 2] = stk_q[2*i+1 -: 2];
        end
    end
endmodule

// File: rtl/cop_read_mux.sv
module cop_read_mux
    import cop_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_ok,
    input  regs_t             regs,
    input  logic [DATA_W-1:0] count_val,
    input  logic [DATA_W-1:0] compare_val,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            case (addr)
                RN_BADADDR: rd_data = regs.bad;
                RN_COUNT:   rd_data = count_val;
                RN_COMPARE: rd_data = compare_val;
                RN_STATUS:  rd_data = stat_word(regs.stat);
                RN_CAUSE:   rd_data = {{(DATA_W-CODE_W-2){1'b0}}, regs.code, 2'b00};
                RN_EPC:     rd_data = regs.epc;
                RN_HOSTIN:  rd_data = {{(DATA_W-HOST_W){1'b0}}, regs.hin};
                RN_HOSTOUT: rd_data = {{(DATA_W-HOST_W){1'b0}}, regs.hout};
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/cop_ctrl_regs.sv
module cop_ctrl_regs
    import cop_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              unusable_fault,
    input  logic              exc_enter,
    input  logic              exc_return,
    input  logic [DATA_W-1:0] exc_pc,
    input  logic [DATA_W-1:0] exc_badaddr,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              host_wr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_out,
    input  logic [DATA_W-1:0] count_val,
    input  logic [DATA_W-1:0] compare_val,
    output logic              tmr_we,
    output logic              tmr_sel,
    output logic              kernel_mode,
    output logic              irq_enable,
    output logic [MASK_W-1:0] irq_mask
);
    regs_t state_d, state_q;
    logic rd_ok, wr_ok;
    logic [STK_W-1:0] stk_next;

    cop_access_check u_chk_acc (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .user_mode (state_q.stat.stk[1]),
        .cu0       (state_q.stat.cu0),
        .exc_enter (exc_enter),
        .fault     (unusable_fault),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok)
    );

    cop_mode_stack #(.N_PAIRS(PAIRS)) u_stack (
        .stk_q (state_q.stat.stk),
        .push  (exc_enter),
        .pop   (exc_return && !exc_enter),
        .stk_d (stk_next)
    );

    cop_read_mux u_rmux (
        .addr        (acc_addr),
        .rd_ok       (rd_ok),
        .regs        (state_q),
        .count_val   (count_val),
        .compare_val (compare_val),
        .rd_data     (rd_data)
    );

    always_comb begin
        state_d = state_q;
        state_d.stat.stk = stk_next;
        if (host_wr) state_d.hin = host_wdata;
        if (exc_enter) begin
            state_d.epc  = exc_pc;
            state_d.bad  = exc_badaddr;
            state_d.code = exc_code;
        end else if (wr_ok) begin
            case (acc_addr)
                RN_STATUS: begin
                    state_d.stat.cu0 = acc_wdata[28];
                    state_d.stat.im  = acc_wdata[15:8];
                    state_d.stat.stk = acc_wdata[STK_W-1:0];
                end
                RN_EPC:     state_d.epc  = acc_wdata;
                RN_HOSTOUT: state_d.hout = acc_wdata[HOST_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign tmr_we      = wr_ok && (acc_addr == RN_COUNT || acc_addr == RN_COMPARE);
    assign tmr_sel     = (acc_addr == RN_COMPARE);
    assign host_out    = state_q.hout;
    assign kernel_mode = !state_q.stat.stk[1];
    assign irq_enable  = state_q.stat.stk[0];
    assign irq_mask    = state_q.stat.im;
endmodule

// File: rtl/cop_ctrl_regs_chk.sv
module cop_ctrl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        exc_enter,
    input logic        exc_return,
    input logic [31:0] exc_pc,
    input logic        unusable_fault,
    input logic        kernel_mode,
    input logic        irq_enable,
    input logic [7:0]  host_out,
    input logic        tmr_we,
    input logic [5:0]  stk,
    input logic [31:0] epc
);
    // R3
    kernel_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unusable_fault |-> !kernel_mode);

    // R3
    refused_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unusable_fault |=> $stable(host_out));

    // R4
    entry_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> kernel_mode && !irq_enable);

    // R4
    entry_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> epc == $past(exc_pc));

    // R5
    return_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_return && !exc_enter && !(acc_valid && acc_write && !unusable_fault)
        |=> stk[1:0] == $past(stk[3:2]));

    // R9
    timer_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_we |-> acc_valid && acc_write && !unusable_fault && !exc_enter);
endmodule

bind cop_ctrl_regs cop_ctrl_regs_chk u_bound_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_valid      (acc_valid),
    .acc_write      (acc_write),
    .exc_enter      (exc_enter),
    .exc_return     (exc_return),
    .exc_pc         (exc_pc),
    .unusable_fault (unusable_fault),
    .kernel_mode    (kernel_mode),
    .irq_enable     (irq_enable),
    .host_out       (host_out),
    .tmr_we         (tmr_we),
    .stk            (state_q.stat.stk),
    .epc            (state_q.epc)
);

// File: tb/cop_ctrl_regs_test.sv
module cop_ctrl_regs_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_write = 0;
    logic [4:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic        unusable_fault;
    logic        exc_enter = 0, exc_return = 0;
    logic [31:0] exc_pc = '0, exc_badaddr = '0;
    logic [4:0]  exc_code = '0;
    logic        host_wr = 0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_out;
    logic [31:0] count_val = 32'h0000_1111, compare_val = 32'h0000_2222;
    logic        tmr_we, tmr_sel, kernel_mode, irq_enable;
    logic [7:0]  irq_mask;

    cop_ctrl_regs uut (.*);

    int checks = 0, fails = 0;
    string req = "R1";
    logic [31:0] m_stat = 0, m_epc = 0, m_bad = 0;
    logic [4:0]  m_code = 0;
    logic [7:0]  m_from = 0, m_to = 0;

    task automatic chk(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a)
            5'd8:  return m_bad;
            5'd9:  return count_val;
            5'd11: return compare_val;
            5'd12: return m_stat;
            5'd13: return {25'b0, m_code, 2'b00};
            5'd14: return m_epc;
            5'd20: return {24'b0, m_from};
            5'd21: return {24'b0, m_to};
            default: return 32'h0;
        endcase
    endfunction

    task automatic cyc();
        bit ok_acc, e_fault, e_we;
        logic [31:0] e_rd;
        #5;
        ok_acc  = !m_stat[1] || m_stat[28];
        e_fault = acc_valid && !ok_acc;
        e_rd    = (acc_valid && ok_acc && !acc_write) ? m_read(acc_addr) : 32'h0;
        e_we    = acc_valid && acc_write && ok_acc && !exc_enter
                  && (acc_addr == 5'd9 || acc_addr == 5'd11);
        chk(unusable_fault == e_fault, req, "fault", {31'b0, unusable_fault}, {31'b0, e_fault});
        chk(rd_data == e_rd, req, "rd_data", rd_data, e_rd);
        chk(tmr_we == e_we, req, "tmr_we", {31'b0, tmr_we}, {31'b0, e_we});
        if (e_we) chk(tmr_sel == (acc_addr == 5'd11), req, "tmr_sel",
                      {31'b0, tmr_sel}, {31'b0, acc_addr == 5'd11});
        @(posedge clk);
        if (host_wr) m_from = host_wdata;
        if (exc_enter) begin
            m_stat[5:0] = {m_stat[3:0], 2'b00};
            m_epc = exc_pc; m_bad = exc_badaddr; m_code = exc_code;
        end else begin
            if (exc_return) m_stat[5:0] = {m_stat[5:4], m_stat[5:2]};
            if (acc_valid && acc_write && ok_acc) begin
                case (acc_addr)
                    5'd12: m_stat = acc_wdata & 32'h1000_FF3F;
                    5'd14: m_epc  = acc_wdata;
                    5'd21: m_to   = acc_wdata[7:0];
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        chk(host_out == m_to, req, "host_out", {24'b0, host_out}, {24'b0, m_to});
        chk(kernel_mode == !m_stat[1], req, "kernel_mode (R11)", {31'b0, kernel_mode}, {31'b0, !m_stat[1]});
        chk(irq_enable == m_stat[0], req, "irq_enable (R11)", {31'b0, irq_enable}, {31'b0, m_stat[0]});
        chk(irq_mask == m_stat[15:8], req, "irq_mask (R11)", {24'b0, irq_mask}, {24'b0, m_stat[15:8]});
        acc_valid = 0; acc_write = 0; exc_enter = 0; exc_return = 0; host_wr = 0;
    endtask

    task automatic rd(logic [4:0] a);
        acc_valid = 1; acc_write = 0; acc_addr = a; cyc();
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d; cyc();
    endtask

    task automatic enter(logic [31:0] pc, logic [31:0] ba, logic [4:0] code);
        exc_pc = pc; exc_badaddr = ba; exc_code = code; exc_enter = 1;
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        req = "R1";
        for (int a = 8; a <= 21; a++) rd(a[4:0]);

        req = "R2";
        wr(5'd12, 32'hFFFF_FFFF);
        rd(5'd12);
        chk(m_stat == 32'h1000_FF3F, "R2", "model status", m_stat, 32'h1000_FF3F);

        req = "R4";
        enter(32'h0000_4000, 32'hDEAD_0004, 5'd5); cyc();
        rd(5'd12); rd(5'd14); rd(5'd8); rd(5'd13);

        req = "R5";
        exc_return = 1; cyc();
        rd(5'd12);

        req = "R3";
        wr(5'd12, 32'h0000_0002);
        rd(5'd12); wr(5'd21, 32'h77); wr(5'd12, 32'h0); rd(5'd14); wr(5'd11, 32'h5);
        enter(32'h10, 32'h20, 5'd2); cyc();
        rd(5'd12);
        wr(5'd12, 32'h1000_0003); rd(5'd12); wr(5'd21, 32'h3C); rd(5'd21);

        req = "R6";
        enter(32'h30, 32'h40, 5'd9); acc_valid = 1; acc_write = 1;
        acc_addr = 5'd12; acc_wdata = 32'hFFFF_FFFF; cyc();
        enter(32'h50, 32'h60, 5'd1); acc_valid = 1; acc_write = 1;
        acc_addr = 5'd9; acc_wdata = 32'h9; cyc();
        enter(32'h70, 32'h80, 5'd3); acc_valid = 1; acc_write = 1;
        acc_addr = 5'd21; acc_wdata = 32'hEE; cyc();
        enter(32'h90, 32'hA0, 5'd4); exc_return = 1; cyc();
        exc_return = 1; acc_valid = 1; acc_write = 1; acc_addr = 5'd12;
        acc_wdata = 32'h0000_A524; cyc();
        rd(5'd12);

        req = "R7";
        host_wr = 1; host_wdata = 8'hA5; acc_valid = 1; acc_addr = 5'd20; cyc();
        rd(5'd20); wr(5'd20, 32'h11); rd(5'd20);

        req = "R8";
        wr(5'd21, 32'h0000_1234); rd(5'd21);

        req = "R9";
        rd(5'd9); rd(5'd11); wr(5'd9, 32'h1); wr(5'd11, 32'h2);

        req = "R10";
        wr(5'd8, 32'h1234_5678); wr(5'd13, 32'hFFFF_FFFF); wr(5'd10, 32'hFFFF_FFFF);
        wr(5'd31, 32'h1);
        for (int a = 0; a < 32; a++) rd(a[4:0]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule